// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This block is the register-file and arithmetic slice of a small 16-bit word-addressed processor. It holds eight general-purpose registers and performs the three operate instructions: add, bitwise and, and bitwise complement. It also keeps a three-flag sign register that reports whether the last value written to a register was negative, zero or positive. Branch logic elsewhere reads these flags.

The surrounding pipeline presents one instruction word per cycle, qualified by a valid strobe. For load instructions it also presents the value fetched from memory, together with a write-select that says the value is ready. Operate results and load data both go into the register file and the flag register on the next rising clock edge. The two register read ports are combinational and are addressed by the source fields of the current instruction. They return the values held before the write on that edge.

Top module: `opu_core`

## Requirements
- R1: After reset all eight registers read 0 and the flags are N=0, Z=1, P=0.
- R2: ADD (opcode 0001 in bits [15:12]) with bit 5 = 0 writes (reg[[8:6]] + reg[[2:0]]) mod 2^16 to reg[[11:9]]. The sum also appears on alu_o in the same cycle.
- R3: ADD and AND with bit 5 = 1 use bits [4:0], sign-extended to 16 bits, as the second operand in place of the second register.
- R4: AND (opcode 0101) writes the bitwise and of its two operands to reg[[11:9]].
- R5: NOT (opcode 1001) whose bits [5:0] are 111111 writes the complement of reg[[8:6]] to reg[[11:9]].
- R6: A valid NOT whose bits [5:0] are not all ones drives illegal_o high in that cycle and changes no register and no flag.
- R7: Every register write sets exactly one flag on the same clock edge. N is set when bit 15 of the written value is 1, Z when all 16 bits are 0, and P otherwise.
- R8: A load opcode (LD 0010, LDI 1010, LDR 0110) with ld_we_i high writes ld_data_i to reg[[11:9]] and updates the flags from that value.
- R9: Nothing is written and the flags hold when insn_vld_i is low, when the opcode is a load and ld_we_i is low, or when the opcode is any other non-operate opcode (stores, branches, jumps, traps, address loads). On operate opcodes ld_we_i has no effect.
- R10: rd_a_o shows reg[[8:6]] and rd_b_o shows reg[[2:0]] combinationally. alu_o is 0 for opcodes other than ADD, AND and NOT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_vld_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 16 | Instruction word |
| ld_data_i | input | 16 | Value returned by a load |
| ld_we_i | input | 1 | Load data is ready to be written |
| rd_a_o | output | 16 | Register addressed by bits [8:6] |
| rd_b_o | output | 16 | Register addressed by bits [2:0] |
| alu_o | output | 16 | Operate result for the current instruction |
| illegal_o | output | 1 | Malformed complement instruction |
| flag_n_o | output | 1 | Last written value was negative |
| flag_z_o | output | 1 | Last written value was zero |
| flag_p_o | output | 1 | Last written value was positive |

## Verification
The bench targets these corner cases:

- Immediates of -16 and +15. A design that zero-extends the immediate gets these sums wrong.
- An add that wraps into bit 15. A design that takes the sign from a carry flags it wrongly.
- A complement whose low field is off by one bit. A design that does not check that field writes a register or moves the flags.
- Store, branch, jump and trap words, including ones sent with the load write-select raised. A design that lets these through corrupts a register or the flags.
- A load opcode with the write-select low. A design that ignores the select updates the flags too early.

After the directed cases, a long random run of mixed opcodes is compared with a behavioural model on every cycle.

// File: rtl/opu_pkg.sv
package opu_pkg;

    localparam int INSN_W = 16;
    localparam int NUM_REGS = 8;
    localparam int REG_AW = $clog2(NUM_REGS);
    localparam int IMM_W = 5;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;
    localparam logic [3:0] OPC_LD  = 4'b0010;
    localparam logic [3:0] OPC_LDI = 4'b1010;
    localparam logic [3:0] OPC_LDR = 4'b0110;

    typedef enum logic [1:0] {
        ALU_NONE = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_AND  = 2'd2,
        ALU_INV  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } nzp_t;

endpackage

// File: rtl/opu_regfile.sv
module opu_regfile #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     ra_addr,
    input  logic [AW-1:0]     rb_addr,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data
);

    logic [DATA_W-1:0] mem_d [NREGS];
    logic [DATA_W-1:0] mem_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else begin
                    mem_q[g] <= mem_d[g];
                end
            end
        end
    endgenerate

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];

    // R8
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/opu_alu.sv
module opu_alu
    import opu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd_b;

    assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign opnd_b  = use_imm ? imm_ext : src_b;

    always_comb begin
        unique case (op)
            ALU_ADD: result = src_a + opnd_b;
            ALU_AND: result = src_a & opnd_b;
            ALU_INV: result = ~src_a;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/opu_flags.sv
module opu_flags
    import opu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output nzp_t              flags
);

    nzp_t flags_d;
    nzp_t flags_q;

    always_comb begin
        flags_d = flags_q;
        if (we) begin
            flags_d.n = wdata[DATA_W-1];
            flags_d.z = (wdata == '0);
            flags_d.p = !wdata[DATA_W-1] && (wdata != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '{n: 1'b0, z: 1'b1, p: 1'b0};
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

    // R7
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({flags_q.n, flags_q.z, flags_q.p}));

    // R7
    zero_sets_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata == '0) |=> flags_q.z);

    // R9
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flags_q));

endmodule

// File: rtl/opu_core.sv
module opu_core
    import opu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_vld_i,
    input  logic [15:0]       insn_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              ld_we_i,
    output logic [DATA_W-1:0] rd_a_o,
    output logic [DATA_W-1:0] rd_b_o,
    output logic [DATA_W-1:0] alu_o,
    output logic              illegal_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_p_o
);

    typedef struct packed {
        alu_op_e alu_op;
        logic    wr_en;
        logic    wr_from_ld;
        logic    bad_insn;
    } dec_t;

    dec_t              dec_d;
    logic [3:0]        opcode;
    logic              is_load;
    logic [DATA_W-1:0] wr_data;
    nzp_t              flags;

    assign opcode  = insn_i[15:12];
    assign is_load = (opcode == OPC_LD) || (opcode == OPC_LDI) || (opcode == OPC_LDR);

    always_comb begin
        dec_d = '{alu_op: ALU_NONE, wr_en: 1'b0, wr_from_ld: 1'b0, bad_insn: 1'b0};
        case (opcode)
            OPC_ADD: dec_d.alu_op = ALU_ADD;
            OPC_AND: dec_d.alu_op = ALU_AND;
            OPC_NOT: dec_d.alu_op = ALU_INV;
            default: dec_d.alu_op = ALU_NONE;
        endcase
        if (insn_vld_i) begin
            if (opcode == OPC_NOT && insn_i[5:0] != 6'h3f) begin
                dec_d.bad_insn = 1'b1;
            end else if (dec_d.alu_op != ALU_NONE) begin
                dec_d.wr_en = 1'b1;
            end else if (is_load && ld_we_i) begin
                dec_d.wr_en      = 1'b1;
                dec_d.wr_from_ld = 1'b1;
            end
        end
    end

    opu_regfile #(
        .DATA_W (DATA_W),
        .NREGS  (NUM_REGS)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (dec_d.wr_en),
        .waddr   (insn_i[11:9]),
        .wdata   (wr_data),
        .ra_addr (insn_i[8:6]),
        .rb_addr (insn_i[2:0]),
        .ra_data (rd_a_o),
        .rb_data (rd_b_o)
    );

    opu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op      (dec_d.alu_op),
        .use_imm (insn_i[5]),
        .imm     (insn_i[4:0]),
        .src_a   (rd_a_o),
        .src_b   (rd_b_o),
        .result  (alu_o)
    );

    assign wr_data = dec_d.wr_from_ld ? ld_data_i : alu_o;

    opu_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dec_d.wr_en),
        .wdata (wr_data),
        .flags (flags)
    );

    assign illegal_o = dec_d.bad_insn;
    assign flag_n_o  = flags.n;
    assign flag_z_o  = flags.z;
    assign flag_p_o  = flags.p;

    // R6
    illegal_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> $stable({flag_n_o, flag_z_o, flag_p_o}));

    // R9
    idle_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld_i |=> $stable({flag_n_o, flag_z_o, flag_p_o}));

endmodule

// File: tb/opu_core_tb.sv
`timescale 1ns/1ps
module opu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_vld_i = 1'b0;
    logic [15:0] insn_i = '0;
    logic [15:0] ld_data_i = '0;
    logic        ld_we_i = 1'b0;
    logic [15:0] rd_a_o, rd_b_o, alu_o;
    logic        illegal_o, flag_n_o, flag_z_o, flag_p_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] m_reg [8];
    logic [2:0]  m_nzp;
    string       prev_tag = "R1";

    always #10 clk = ~clk;

    opu_core u_dut (
        .clk(clk), .rst_n(rst_n), .insn_vld_i(insn_vld_i), .insn_i(insn_i),
        .ld_data_i(ld_data_i), .ld_we_i(ld_we_i), .rd_a_o(rd_a_o), .rd_b_o(rd_b_o),
        .alu_o(alu_o), .illegal_o(illegal_o), .flag_n_o(flag_n_o),
        .flag_z_o(flag_z_o), .flag_p_o(flag_p_o)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(logic v, logic [15:0] ins, logic lwe);
        logic [3:0] op = ins[15:12];
        if (!v) return "R9";
        if (op == 4'b0001) return ins[5] ? "R3" : "R2";
        if (op == 4'b0101) return ins[5] ? "R3" : "R4";
        if (op == 4'b1001) return (ins[5:0] == 6'h3f) ? "R5" : "R6";
        if ((op == 4'b0010 || op == 4'b1010 || op == 4'b0110) && lwe) return "R8";
        return "R9";
    endfunction

    task automatic apply(input logic v, input logic [15:0] ins,
                         input logic [15:0] ld, input logic lwe);
        logic [15:0] a, b, opb, exp_alu, wd;
        logic [3:0]  op;
        logic        bad, wr, isld;
        string       tag;
        @(negedge clk);
        insn_vld_i = v; insn_i = ins; ld_data_i = ld; ld_we_i = lwe;
        #2;
        tag = tag_of(v, ins, lwe);
        op  = ins[15:12];
        a   = m_reg[ins[8:6]];
        b   = m_reg[ins[2:0]];
        opb = ins[5] ? {{11{ins[4]}}, ins[4:0]} : b;
        case (op)
            4'b0001: exp_alu = a + opb;
            4'b0101: exp_alu = a & opb;
            4'b1001: exp_alu = ~a;
            default: exp_alu = 16'h0;
        endcase
        bad  = v && op == 4'b1001 && ins[5:0] != 6'h3f;
        isld = (op == 4'b0010 || op == 4'b1010 || op == 4'b0110);
        // R10 read ports reflect the state left by the previous vector
        check(rd_a_o === a, prev_tag, "R10 rd_a", rd_a_o, a);
        check(rd_b_o === b, prev_tag, "R10 rd_b", rd_b_o, b);
        check({flag_n_o, flag_z_o, flag_p_o} === m_nzp, prev_tag, "R7 flags",
              {13'h0, flag_n_o, flag_z_o, flag_p_o}, {13'h0, m_nzp});
        check(alu_o === exp_alu, tag, "alu_o", alu_o, exp_alu);
        check(illegal_o === bad, "R6", "illegal_o", {15'h0, illegal_o}, {15'h0, bad});
        wr = v && !bad && (op == 4'b0001 || op == 4'b0101 || op == 4'b1001 || (isld && lwe));
        wd = (isld && lwe) ? ld : exp_alu;
        if (wr) begin
            m_reg[ins[11:9]] = wd;
            m_nzp = {wd[15], wd == 16'h0, !wd[15] && wd != 16'h0};
        end
        prev_tag = tag;
    endtask

    function automatic logic [15:0] mk(logic [3:0] op, int dr, int s1, logic [5:0] low);
        return {op, 3'(dr), 3'(s1), low};
    endfunction

    initial begin
        #(20 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_nzp = 3'b010;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state read back through both ports
        for (int i = 0; i < 8; i++) apply(1'b1, mk(4'b0000, 0, i, 6'(i)), 16'h0, 1'b0);
        // R8 loads
        apply(1'b1, mk(4'b0010, 1, 0, 6'h0), 16'h1234, 1'b1);
        apply(1'b1, mk(4'b1010, 2, 0, 6'h0), 16'h8000, 1'b1);
        apply(1'b1, mk(4'b0110, 3, 0, 6'h0), 16'h0000, 1'b1);
        apply(1'b1, mk(4'b0010, 4, 0, 6'h0), 16'h7fff, 1'b1);
        // R2 register add, including wrap into bit 15
        apply(1'b1, mk(4'b0001, 5, 1, 6'h02), 16'h0, 1'b0);
        apply(1'b1, mk(4'b0001, 6, 4, 6'h04), 16'h0, 1'b0);
        // R3 immediates -16 and +15
        apply(1'b1, mk(4'b0001, 7, 1, 6'h30), 16'h0, 1'b0);
        apply(1'b1, mk(4'b0001, 0, 3, 6'h2f), 16'h0, 1'b0);
        apply(1'b1, mk(4'b0101, 5, 1, 6'h3f), 16'h0, 1'b0);
        // R4 and to zero, and nonzero
        apply(1'b1, mk(4'b0101, 6, 2, 6'h04), 16'h0, 1'b0);
        apply(1'b1, mk(4'b0101, 7, 1, 6'h01), 16'h0, 1'b0);
        // R5 complement
        apply(1'b1, mk(4'b1001, 3, 3, 6'h3f), 16'h0, 1'b0);
        apply(1'b1, mk(4'b1001, 2, 4, 6'h3f), 16'h0, 1'b0);
        // R6 malformed complement
        apply(1'b1, mk(4'b1001, 1, 1, 6'h3e), 16'h0, 1'b0);
        apply(1'b1, mk(4'b1001, 0, 0, 6'h1f), 16'h0, 1'b1);
        // R9 ignored cases
        apply(1'b1, mk(4'b0011, 1, 0, 6'h0), 16'hffff, 1'b1);
        apply(1'b1, mk(4'b1100, 1, 2, 6'h0), 16'hffff, 1'b1);
        apply(1'b1, mk(4'b1111, 1, 0, 6'h25), 16'hffff, 1'b1);
        apply(1'b1, mk(4'b1110, 1, 0, 6'h0), 16'h0000, 1'b1);
        apply(1'b1, mk(4'b0010, 1, 0, 6'h0), 16'h0000, 1'b0);
        apply(1'b0, mk(4'b0001, 1, 1, 6'h01), 16'h0, 1'b0);
        apply(1'b1, mk(4'b0001, 1, 1, 6'h01), 16'h0000, 1'b1);
        apply(1'b1, mk(4'b0000, 0, 1, 6'h1), 16'h0, 1'b0);
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] ops [13] = '{4'h1, 4'h5, 4'h9, 4'h2, 4'hA, 4'h6, 4'h3,
                                     4'h0, 4'hC, 4'hF, 4'hB, 4'h7, 4'hE};
            logic [15:0] ins;
            ins = {ops[$urandom_range(0, 12)], 12'($urandom)};
            if (ins[15:12] == 4'h9 && $urandom_range(0, 3) != 0) ins[5:0] = 6'h3f;
            apply($urandom_range(0, 7) != 0, ins, 16'($urandom), 1'($urandom));
        end
        apply(1'b1, mk(4'b0000, 0, 0, 6'h0), 16'h0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule